// File: doc/BRIEF.md
# Slot-Locked Hardware Thread Sequencer

This block lives inside one core of an eight-core machine. The eight cores share one memory through a rotating access scheme, and each core gets its access slot once every 8 clocks. The sequencer runs up to four hardware threads on the core. It changes the running thread only on the cycle when the core's slot strobe arrives. No instruction asks for a switch, so each thread's timing is fixed and can be known in advance.

A two-bit mode picks the thread layout, and each layout divides the 512-word local register space into fixed windows. The top sixteen words, $1F0 to $1FF, hold I/O registers. Every thread can reach them.

| Mode code | Layout | Slot order | Windows |
|---|---|---|---|
| 0 | single thread | 0 | $000-$1EF |
| 1 | two threads | 0, 1 | t0 $000-$0FF, t1 $100-$1EF |
| 2 | three threads, unequal shares | 0, 1, 0, 2 | t0 $000-$0FF, t1 $100-$17F, t2 $180-$1EF |
| 3 | four threads | 0, 1, 2, 3 | $000-$07F, $080-$0FF, $100-$17F, $180-$1EF |

The sequencer keeps a program counter and a pair of flags for each thread. The execute stage updates the counter and the flags of the thread that is running. For every fetch the block gives out:
- the active thread index,
- that thread's PC,
- its flags,
- its window bounds,
- a local operand address translated into the active window.

Top module: `slot_thread_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, the block is in mode 0 with thread 0 active. Every PC and every flag pair is zero, and the window is $000-$1EF.
- R2: The active thread changes only after a clock edge at which the slot strobe was high. The one exception is a mode reload (R11).
- R3: In mode 3 the slot order is 0,1,2,3, repeating. The windows are $000-$07F, $080-$0FF, $100-$17F and $180-$1EF.
- R4: In mode 1 the slots alternate between threads 0 and 1. Thread 0 owns $000-$0FF and thread 1 owns $100-$1EF.
- R5: In mode 2 the slot order is 0,1,0,2, repeating. The windows are $000-$0FF for thread 0, $100-$17F for thread 1 and $180-$1EF for thread 2.
- R6: In mode 0 thread 0 is always active, whatever the slot strobe does, and its window is $000-$1EF.
- R7: A local address in $1F0-$1FF is passed to the translated address unchanged, in every mode and for every thread.
- R8: An address inside the active window maps to itself. Any other address below $1F0 maps to window base + (address mod window size).
- R9: A PC write changes only the active thread's PC. The written value is translated as in R8. Each thread keeps its PC across switches. A write in the same cycle as a slot still lands in the outgoing thread.
- R10: A flag write (bit 1 = carry, bit 0 = zero) changes only the active thread's flags. Each thread keeps its flags across switches.
- R11: A mode input that differs from the current mode is taken at the next edge. In the cycle after that edge the new mode is in force, thread 0 is active, the slot order restarts, every PC holds its new window base and every flag pair is zero. Slot strobes and writes at that edge are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_i | input | 1 | Shared-memory slot strobe for this core |
| mode_i | input | 2 | Thread layout: 0 single, 1 two, 2 three, 3 four |
| pc_we_i | input | 1 | Write the active thread's PC |
| pc_wdata_i | input | ADDR_W (9) | New PC value, translated before storing |
| flag_we_i | input | 1 | Write the active thread's flags |
| flag_i | input | FLAG_W (2) | New flags, bit 1 carry, bit 0 zero |
| laddr_i | input | ADDR_W (9) | Local operand address to translate |
| thr_o | output | 2 | Active thread index |
| pc_o | output | ADDR_W (9) | PC of the active thread |
| flags_o | output | FLAG_W (2) | Flags of the active thread |
| base_o | output | ADDR_W (9) | First word of the active window |
| limit_o | output | ADDR_W (9) | Last word of the active window |
| paddr_o | output | ADDR_W (9) | Translated local address |

## Verification
Some rules can be checked on every cycle, and the assertions cover those:
- the thread holds between slots,
- the four-thread order steps by one,
- the three-thread schedule returns to thread 0 after every other slot,
- the single-thread mode never leaves thread 0,
- I/O addresses pass through unchanged,
- a translated address always falls inside the active window,
- a mode reload starts thread 0 at its base.

The exact wrap values need the bench's scenarios, and so do PC and flag retention for each thread and the exact window bounds in each mode. The bench sweeps every mode through many slots while it writes PCs and flags. After each sweep it drives all 512 local addresses for every thread position.

// File: rtl/sts_pkg.sv
`timescale 1ns/1ps
package sts_pkg;

    typedef enum logic [1:0] {
        MODE_SOLO = 2'd0,
        MODE_DUO  = 2'd1,
        MODE_TRIO = 2'd2,
        MODE_QUAD = 2'd3
    } tmode_e;

    // First word of thread t's window for a local space of 'space' words
    function automatic int win_lo(tmode_e m, int t, int space);
        int q;
        int h;
        q = space / 4;
        h = space / 2;
        case (m)
            MODE_SOLO: return 0;
            MODE_DUO:  return (t % 2 == 1) ? h : 0;
            MODE_TRIO: return (t == 1) ? h : ((t == 2) ? h + q : 0);
            default:   return t * q;
        endcase
    endfunction

    // Last word of thread t's window; the top io_words are excluded
    function automatic int win_hi(tmode_e m, int t, int space, int io_words);
        int q;
        int h;
        int top;
        q   = space / 4;
        h   = space / 2;
        top = space - io_words - 1;
        case (m)
            MODE_SOLO: return top;
            MODE_DUO:  return (t % 2 == 1) ? top : h - 1;
            MODE_TRIO: return (t == 1) ? h + q - 1 : ((t == 2) ? top : h - 1);
            default:   return (t == 3) ? top : t * q + q - 1;
        endcase
    endfunction

endpackage

// File: rtl/sts_order.sv
`timescale 1ns/1ps
module sts_order
    import sts_pkg::*;
#(
    parameter int TW = 2
) (
    input  tmode_e        mode_i,
    input  logic [TW-1:0] pos_i,
    output logic [TW-1:0] thr_o,
    output logic [TW-1:0] pos_nx_o
);

    always_comb begin
        case (mode_i)
            MODE_SOLO: begin
                thr_o    = '0;
                pos_nx_o = '0;
            end
            MODE_DUO: begin
                thr_o    = TW'(pos_i[0]);
                pos_nx_o = TW'(~pos_i[0]);
            end
            MODE_TRIO: begin
                // 0,1,0,2: thread 0 every second slot
                if (!pos_i[0])     thr_o = '0;
                else if (!pos_i[1]) thr_o = TW'(1);
                else               thr_o = TW'(2);
                pos_nx_o = pos_i + TW'(1);
            end
            default: begin
                thr_o    = pos_i;
                pos_nx_o = pos_i + TW'(1);
            end
        endcase
    end

endmodule

// File: rtl/sts_xlate.sv
`timescale 1ns/1ps
module sts_xlate #(
    parameter int ADDR_W   = 9,
    parameter int IO_WORDS = 16
) (
    input  logic [ADDR_W-1:0] laddr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] limit_i,
    output logic [ADDR_W-1:0] paddr_o
);

    localparam int SPACE = 1 << ADDR_W;
    localparam int MINW  = SPACE / 4 - IO_WORDS;
    localparam int FOLDS = (SPACE + MINW - 1) / MINW;
    localparam logic [ADDR_W-1:0] IO_BASE = ADDR_W'(SPACE - IO_WORDS);

    logic              is_io;
    logic              in_win;
    logic [ADDR_W:0]   size;
    logic [ADDR_W:0]   rem;

    always_comb begin
        is_io  = laddr_i >= IO_BASE;
        in_win = (laddr_i >= base_i) && (laddr_i <= limit_i);
        size   = {1'b0, limit_i} - {1'b0, base_i} + (ADDR_W+1)'(1);
        rem    = {1'b0, laddr_i};
        for (int k = 0; k < FOLDS; k++) begin
            if (rem >= size) rem = rem - size;
        end
        paddr_o = (is_io || in_win) ? laddr_i : base_i + rem[ADDR_W-1:0];
    end

endmodule

// File: rtl/slot_thread_seq.sv
`timescale 1ns/1ps
module slot_thread_seq
    import sts_pkg::*;
#(
    parameter int ADDR_W   = 9,
    parameter int NTHR     = 4,
    parameter int FLAG_W   = 2,
    parameter int IO_WORDS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_i,
    input  logic [1:0]        mode_i,
    input  logic              pc_we_i,
    input  logic [ADDR_W-1:0] pc_wdata_i,
    input  logic              flag_we_i,
    input  logic [FLAG_W-1:0] flag_i,
    input  logic [ADDR_W-1:0] laddr_i,
    output logic [1:0]        thr_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic [FLAG_W-1:0] flags_o,
    output logic [ADDR_W-1:0] base_o,
    output logic [ADDR_W-1:0] limit_o,
    output logic [ADDR_W-1:0] paddr_o
);

    localparam int TW    = $clog2(NTHR);
    localparam int SPACE = 1 << ADDR_W;

    typedef struct packed {
        tmode_e                         mode;
        logic [TW-1:0]                  pos;
        logic [NTHR-1:0][ADDR_W-1:0]    pc;
        logic [NTHR-1:0][FLAG_W-1:0]    flg;
    } state_t;

    state_t            st_d, st_q;
    logic [TW-1:0]     thr;
    logic [TW-1:0]     pos_nx;
    logic [ADDR_W-1:0] act_base;
    logic [ADDR_W-1:0] act_limit;
    logic [ADDR_W-1:0] pc_wrap;
    tmode_e            mode_req;
    tmode_e            mode_cur;
    logic              mode_chg;

    assign mode_req = tmode_e'(mode_i);
    assign mode_cur = st_q.mode;

    sts_order #(.TW(TW)) u_order (
        .mode_i   (st_q.mode),
        .pos_i    (st_q.pos),
        .thr_o    (thr),
        .pos_nx_o (pos_nx)
    );

    always_comb begin
        act_base  = ADDR_W'(win_lo(st_q.mode, int'(thr), SPACE));
        act_limit = ADDR_W'(win_hi(st_q.mode, int'(thr), SPACE, IO_WORDS));
    end

    sts_xlate #(.ADDR_W(ADDR_W), .IO_WORDS(IO_WORDS)) u_op_xlate (
        .laddr_i (laddr_i),
        .base_i  (act_base),
        .limit_i (act_limit),
        .paddr_o (paddr_o)
    );

    sts_xlate #(.ADDR_W(ADDR_W), .IO_WORDS(IO_WORDS)) u_pc_xlate (
        .laddr_i (pc_wdata_i),
        .base_i  (act_base),
        .limit_i (act_limit),
        .paddr_o (pc_wrap)
    );

    always_comb begin
        st_d     = st_q;
        mode_chg = mode_req != st_q.mode;
        if (mode_chg) begin
            st_d.mode = mode_req;
            st_d.pos  = '0;
            for (int t = 0; t < NTHR; t++) begin
                st_d.pc[t]  = ADDR_W'(win_lo(mode_req, t, SPACE));
                st_d.flg[t] = '0;
            end
        end else begin
            if (pc_we_i)   st_d.pc[thr]  = pc_wrap;
            if (flag_we_i) st_d.flg[thr] = flag_i;
            if (slot_i)    st_d.pos      = pos_nx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.mode <= MODE_SOLO;
            st_q.pos  <= '0;
            st_q.pc   <= '0;
            st_q.flg  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign thr_o   = 2'(thr);
    assign pc_o    = st_q.pc[thr];
    assign flags_o = st_q.flg[thr];
    assign base_o  = act_base;
    assign limit_o = act_limit;

endmodule

// File: rtl/sts_checker.sv
`timescale 1ns/1ps
module sts_checker #(
    parameter int ADDR_W   = 9,
    parameter int IO_WORDS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              slot_i,
    input logic [1:0]        mode_i,
    input logic [1:0]        mode_q,
    input logic [1:0]        thr_o,
    input logic [ADDR_W-1:0] pc_o,
    input logic [ADDR_W-1:0] base_o,
    input logic [ADDR_W-1:0] limit_o,
    input logic [ADDR_W-1:0] laddr_i,
    input logic [ADDR_W-1:0] paddr_o
);

    localparam logic [ADDR_W-1:0] IO_BASE = ADDR_W'((1 << ADDR_W) - IO_WORDS);
    localparam logic [ADDR_W-1:0] TOP     = IO_BASE - ADDR_W'(1);

    p_hold_between_slots_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot_i && mode_i == mode_q) |=> $stable(thr_o));

    p_quad_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd3 && slot_i && mode_i == mode_q) |=> thr_o == 2'($past(thr_o) + 2'd1));

    p_duo_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd1) |-> thr_o <= 2'd1);

    p_trio_return_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd2 && slot_i && thr_o != 2'd0 && mode_i == mode_q) |=> thr_o == 2'd0);

    p_solo_fixed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == 2'd0) |-> (thr_o == 2'd0 && base_o == '0 && limit_o == TOP));

    p_io_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (laddr_i >= IO_BASE) |-> paddr_o == laddr_i);

    p_in_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (laddr_i < IO_BASE) |-> (paddr_o >= base_o && paddr_o <= limit_o));

    p_reload_base_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != mode_q) |=> (thr_o == 2'd0 && pc_o == base_o));

endmodule

bind slot_thread_seq sts_checker #(.ADDR_W(ADDR_W), .IO_WORDS(IO_WORDS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot_i  (slot_i),
    .mode_i  (mode_i),
    .mode_q  (mode_cur),
    .thr_o   (thr_o),
    .pc_o    (pc_o),
    .base_o  (base_o),
    .limit_o (limit_o),
    .laddr_i (laddr_i),
    .paddr_o (paddr_o)
);

// File: tb/slot_thread_seq_test.sv
`timescale 1ns/1ps
module slot_thread_seq_test;

    localparam int AW = 9;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slot = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic          pc_we = 1'b0;
    logic [AW-1:0] pc_wdata = '0;
    logic          flg_we = 1'b0;
    logic [1:0]    flg_wdata = '0;
    logic [AW-1:0] laddr = '0;

    logic [1:0]    thr_o;
    logic [AW-1:0] pc_o;
    logic [1:0]    flags_o;
    logic [AW-1:0] base_o;
    logic [AW-1:0] limit_o;
    logic [AW-1:0] paddr_o;

    always #10 clk = ~clk;

    slot_thread_seq uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_i     (slot),
        .mode_i     (mode),
        .pc_we_i    (pc_we),
        .pc_wdata_i (pc_wdata),
        .flag_we_i  (flg_we),
        .flag_i     (flg_wdata),
        .laddr_i    (laddr),
        .thr_o      (thr_o),
        .pc_o       (pc_o),
        .flags_o    (flags_o),
        .base_o     (base_o),
        .limit_o    (limit_o),
        .paddr_o    (paddr_o)
    );

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    // reference model state
    int mode_m = 0;
    int pos_m = 0;
    int pc_m[4];
    int fl_m[4];
    int prev_thr = 0;
    bit prev_quiet = 0;
    bit prev_reload = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int e_base(int m, int t);
        case (m)
            0: return 0;
            1: return (t % 2 == 1) ? 256 : 0;
            2: return (t == 1) ? 256 : ((t == 2) ? 384 : 0);
            default: return t * 128;
        endcase
    endfunction

    function automatic int e_lim(int m, int t);
        case (m)
            0: return 495;
            1: return (t % 2 == 1) ? 495 : 255;
            2: return (t == 1) ? 383 : ((t == 2) ? 495 : 255);
            default: return (t == 3) ? 495 : t * 128 + 127;
        endcase
    endfunction

    function automatic int e_thr(int m, int p);
        case (m)
            0: return 0;
            1: return p % 2;
            2: return (p % 2 == 0) ? 0 : ((p == 1) ? 1 : 2);
            default: return p;
        endcase
    endfunction

    function automatic int e_len(int m);
        return (m == 0) ? 1 : ((m == 1) ? 2 : 4);
    endfunction

    function automatic int e_xl(int m, int t, int a);
        int b;
        int l;
        b = e_base(m, t);
        l = e_lim(m, t);
        if (a >= 496 || (a >= b && a <= l)) return a;
        return b + (a % (l - b + 1));
    endfunction

    function automatic string mode_tag(int m);
        case (m)
            0: return "R6";
            1: return "R4";
            2: return "R5";
            default: return "R3";
        endcase
    endfunction

    // called just after a negedge with inputs set; checks then advances model
    task automatic cycle();
        int t;
        int mi;
        #1;
        t = e_thr(mode_m, pos_m);
        chk({mode_tag(mode_m), " thread"}, thr_o, t);
        if (prev_quiet) chk("R2 thread held", thr_o, prev_thr);
        chk(prev_reload ? "R11 pc at base" : "R9 pc", pc_o, pc_m[t]);
        chk(prev_reload ? "R11 flags clear" : "R10 flags", flags_o, fl_m[t]);
        chk({mode_tag(mode_m), " base"}, base_o, e_base(mode_m, t));
        chk({mode_tag(mode_m), " limit"}, limit_o, e_lim(mode_m, t));
        chk((int'(laddr) >= 496) ? "R7 io pass" : "R8 translate", paddr_o,
            e_xl(mode_m, t, int'(laddr)));
        mi = int'(mode);
        prev_thr    = t;
        prev_quiet  = !slot && (mi == mode_m);
        prev_reload = (mi != mode_m);
        if (mi != mode_m) begin
            mode_m = mi;
            pos_m  = 0;
            for (int k = 0; k < 4; k++) begin
                pc_m[k] = e_base(mi, k);
                fl_m[k] = 0;
            end
        end else begin
            if (pc_we)  pc_m[t] = e_xl(mode_m, t, int'(pc_wdata));
            if (flg_we) fl_m[t] = int'(flg_wdata);
            if (slot)   pos_m = (pos_m + 1) % e_len(mode_m);
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic run_mode(input int m, input int nslots);
        mode = 2'(m);
        for (int c = 0; c < nslots * 8; c++) begin
            slot      = (c % 8 == 7);
            pc_we     = (c % 3 == 1);
            pc_wdata  = AW'((c * 37 + m * 11) % 512);
            flg_we    = (c % 5 == 2);
            flg_wdata = 2'(c % 4);
            laddr     = AW'((c * 53) % 512);
            cycle();
        end
        slot = 0; pc_we = 0; flg_we = 0;
    endtask

    task automatic sweep_xlate();
        for (int p = 0; p < 4; p++) begin
            slot = 0; pc_we = 0; flg_we = 0;
            for (int a = 0; a < 512; a++) begin
                laddr = AW'(a);
                #1;
                chk((a >= 496) ? "R7 io pass sweep" : "R8 translate sweep", paddr_o,
                    e_xl(mode_m, e_thr(mode_m, pos_m), a));
            end
            @(negedge clk);
            slot = 1;
            cycle();
            slot = 0;
        end
    endtask

    initial begin
        #(20 * 150000);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: got hang expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 4; k++) begin
            pc_m[k] = 0;
            fl_m[k] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: state held in reset
        chk("R1 reset thread", thr_o, 0);
        chk("R1 reset pc", pc_o, 0);
        chk("R1 reset flags", flags_o, 0);
        chk("R1 reset base", base_o, 0);
        chk("R1 reset limit", limit_o, 495);
        rst_n = 1'b1;
        cycle();
        run_mode(3, 12);
        sweep_xlate();
        run_mode(1, 8);
        sweep_xlate();
        run_mode(2, 12);
        sweep_xlate();
        run_mode(0, 4);
        sweep_xlate();
        run_mode(3, 6);
        run_mode(2, 5);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule